// File: doc/BRIEF.md
# Coprocessor Command/Response Handshake Sequencer

This block sits beside the main processor core and carries one general coprocessor instruction through a register-based dialogue with the coprocessor. When the core hands over an instruction command word, the sequencer writes it, unchanged and undecoded, into the coprocessor's command register over a small register bus. It then reads the coprocessor's response register over and over. Each word it reads holds a response primitive. The sequencer either acts on that primitive or uses it to close the transaction.

There are two service primitives: an effective-address evaluation and an operand transfer. Both go to the core over a request/acknowledge port. The core does the work itself, including fetching any extension words that follow the command word in the instruction stream. A release primitive ends the dialogue with a one-cycle done pulse. The exception is a pending trace: in that case only a release that also reports full completion ends it. Malformed responses and too many come-again answers end the transaction with an error flag and no done pulse.

Top module: `cop_handshake_seq`

## Requirements
- R1: A start seen in the idle state issues a bus write with `bus_write_o`=1 and `bus_sel_o`=0 (command register), whose `bus_wdata_o` equals `cmd_word_i` bit for bit. Exactly one such write is made per transaction.
- R2: After the command write completes, the block issues reads with `bus_write_o`=0 and `bus_sel_o`=1 (response register). The primitive is taken from `bus_rdata_i[2:0]`.
- R3: An access holds `bus_valid_o`, `bus_sel_o` and `bus_write_o` steady until `bus_ready_i` is seen, and only one access is outstanding at a time.
- R4: Primitive 000 (come again) is followed by exactly one cycle with `bus_valid_o` low, then by another read. Consecutive read handshakes are therefore two clocks apart when the bus is always ready.
- R5: Primitive 011 (evaluate address) raises `svc_req_o` with `svc_kind_o`=0, and primitive 100 (move operand) raises it with `svc_kind_o`=1. The request stays high until `svc_ack_i`, with no bus access meanwhile. The response register is then read again.
- R6: Primitive 010 (release, complete) always ends the transaction with a done pulse. Primitive 001 (release, not complete) ends it the same way when the trace flag captured at start is low.
- R7: With the captured trace flag high, primitive 001 behaves like 000: an idle cycle, a new read, and it counts toward the retry limit. Only 010 can then end the transaction normally.
- R8: Primitives 101, 110 and 111 end the transaction with `err_proto_o` set and no done pulse. So does any response word with a nonzero bit above bit 2.
- R9: With limit L on `retry_limit_i`, the (L+1)th come-again answer in a row sets `err_timeout_o` and ends the transaction without a done pulse. A service primitive restarts this count.
- R10: `done_o` lasts exactly one cycle and is high only when the block is idle. `busy_o` is high from the cycle after an accepted start until the transaction ends. A start seen while busy is ignored.
- R11: Error flags stay set after the transaction ends, and the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction (honoured only when idle) |
| cmd_word_i | input | CMD_W | Instruction command word to forward |
| trace_pend_i | input | 1 | Trace pending, captured at start |
| retry_limit_i | input | RETRY_W | Permitted come-again answers in a row |
| bus_valid_o | output | 1 | Register access request |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_sel_o | output | 1 | 0 = command register, 1 = response register |
| bus_wdata_o | output | CMD_W | Write data (command word) |
| bus_ready_i | input | 1 | Access completes this cycle |
| bus_rdata_i | input | RESP_W | Response word read back |
| svc_req_o | output | 1 | Service request to the core |
| svc_kind_o | output | 1 | 0 = evaluate address, 1 = move operand |
| svc_ack_i | input | 1 | Core has finished the service |
| done_o | output | 1 | One-cycle release pulse |
| busy_o | output | 1 | Transaction in progress |
| err_proto_o | output | 1 | Malformed response seen |
| err_timeout_o | output | 1 | Retry limit exceeded |

## Verification
Several primitive sequences are driven, and each one isolates a single part of the main function. A lone release-complete shows the basic write-then-read path. Runs of come-again answers expose the idle-cycle spacing and the limit. Two release-not-complete answers in a row behave differently with and without trace pending, so that pattern shows whether the trace flag is honoured. A sequence that mixes a service between come-again runs shows whether the retry count restarts after a service. A slow bus, a malformed or oversized response word, and a second start sent mid-transaction test holding, error exit and start rejection.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;
  localparam int PRIM_W = 3;

  localparam logic [PRIM_W-1:0] PR_AGAIN    = 3'b000;
  localparam logic [PRIM_W-1:0] PR_REL_PART = 3'b001;
  localparam logic [PRIM_W-1:0] PR_REL_FULL = 3'b010;
  localparam logic [PRIM_W-1:0] PR_EVAL_EA  = 3'b011;
  localparam logic [PRIM_W-1:0] PR_MOVE_OP  = 3'b100;

  localparam logic SEL_CMD  = 1'b0;
  localparam logic SEL_RESP = 1'b1;
  localparam logic KIND_EA  = 1'b0;
  localparam logic KIND_OP  = 1'b1;

  typedef enum logic [1:0] {ACT_AGAIN, ACT_FINISH, ACT_SERVICE, ACT_ERROR} act_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_READ, ST_GAP, ST_SVC} st_e;
endpackage

// File: rtl/cop_prim_decode.sv
module cop_prim_decode
  import cop_seq_pkg::*;
#(
  parameter int RESP_W = 8
) (
  input  logic [RESP_W-1:0] resp_i,
  input  logic              trace_i,
  output act_e              act_o,
  output logic              kind_o
);
  localparam int HI_W = RESP_W - PRIM_W;

  logic [HI_W-1:0]   hi_bits;
  logic [PRIM_W-1:0] code;

  assign hi_bits = resp_i[RESP_W-1:PRIM_W];
  assign code    = resp_i[PRIM_W-1:0];

  always_comb begin
    act_o  = ACT_ERROR;
    kind_o = KIND_EA;
    if (hi_bits == '0) begin
      case (code)
        PR_AGAIN:    act_o = ACT_AGAIN;
        PR_REL_PART: act_o = trace_i ? ACT_AGAIN : ACT_FINISH;
        PR_REL_FULL: act_o = ACT_FINISH;
        PR_EVAL_EA:  begin act_o = ACT_SERVICE; kind_o = KIND_EA; end
        PR_MOVE_OP:  begin act_o = ACT_SERVICE; kind_o = KIND_OP; end
        default:     act_o = ACT_ERROR;
      endcase
    end
  end
endmodule

// File: rtl/cop_retry_ctr.sv
module cop_retry_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         at_limit_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (inc_i)   cnt <= cnt + 1'b1;
  end

  assign at_limit_o = (cnt == limit_i);
endmodule

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq
  import cop_seq_pkg::*;
#(
  parameter int CMD_W   = 16,
  parameter int RESP_W  = 8,
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CMD_W-1:0]   cmd_word_i,
  input  logic               trace_pend_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  output logic               bus_valid_o,
  output logic               bus_write_o,
  output logic               bus_sel_o,
  output logic [CMD_W-1:0]   bus_wdata_o,
  input  logic               bus_ready_i,
  input  logic [RESP_W-1:0]  bus_rdata_i,
  output logic               svc_req_o,
  output logic               svc_kind_o,
  input  logic               svc_ack_i,
  output logic               done_o,
  output logic               busy_o,
  output logic               err_proto_o,
  output logic               err_timeout_o
);
  st_e  state;
  logic trace_q;
  act_e act;
  logic kind;
  logic at_limit;
  logic rd_done;
  logic cnt_clr;
  logic cnt_inc;

  cop_prim_decode #(.RESP_W(RESP_W)) u_dec (
    .resp_i (bus_rdata_i),
    .trace_i(trace_q),
    .act_o  (act),
    .kind_o (kind)
  );

  assign rd_done = (state == ST_READ) && bus_ready_i;
  assign cnt_clr = ((state == ST_IDLE) && start_i) || (rd_done && act == ACT_SERVICE);
  assign cnt_inc = rd_done && (act == ACT_AGAIN) && !at_limit;

  cop_retry_ctr #(.W(RETRY_W)) u_retry (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (cnt_clr),
    .inc_i     (cnt_inc),
    .limit_i   (retry_limit_i),
    .at_limit_o(at_limit)
  );

  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      trace_q       <= 1'b0;
      bus_valid_o   <= 1'b0;
      bus_write_o   <= 1'b0;
      bus_sel_o     <= SEL_CMD;
      bus_wdata_o   <= '0;
      svc_req_o     <= 1'b0;
      svc_kind_o    <= KIND_EA;
      done_o        <= 1'b0;
      err_proto_o   <= 1'b0;
      err_timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            trace_q       <= trace_pend_i;
            err_proto_o   <= 1'b0;
            err_timeout_o <= 1'b0;
            bus_valid_o   <= 1'b1;
            bus_write_o   <= 1'b1;
            bus_sel_o     <= SEL_CMD;
            bus_wdata_o   <= cmd_word_i;
            state         <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (bus_ready_i) begin
            bus_write_o <= 1'b0;
            bus_sel_o   <= SEL_RESP;
            state       <= ST_READ;
          end
        end
        ST_READ: begin
          if (bus_ready_i) begin
            bus_valid_o <= 1'b0;
            case (act)
              ACT_AGAIN: begin
                if (at_limit) begin
                  err_timeout_o <= 1'b1;
                  state         <= ST_IDLE;
                end else begin
                  state <= ST_GAP;
                end
              end
              ACT_FINISH: begin
                done_o <= 1'b1;
                state  <= ST_IDLE;
              end
              ACT_SERVICE: begin
                svc_req_o  <= 1'b1;
                svc_kind_o <= kind;
                state      <= ST_SVC;
              end
              default: begin
                err_proto_o <= 1'b1;
                state       <= ST_IDLE;
              end
            endcase
          end
        end
        ST_GAP: begin
          bus_valid_o <= 1'b1;
          state       <= ST_READ;
        end
        ST_SVC: begin
          if (svc_ack_i) begin
            svc_req_o   <= 1'b0;
            bus_valid_o <= 1'b1;
            state       <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cop_handshake_seq_chk.sv
module cop_handshake_seq_chk #(
  parameter int CMD_W   = 16,
  parameter int RESP_W  = 8,
  parameter int RETRY_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [CMD_W-1:0]   cmd_word_i,
  input logic               trace_pend_i,
  input logic [RETRY_W-1:0] retry_limit_i,
  input logic               bus_valid_o,
  input logic               bus_write_o,
  input logic               bus_sel_o,
  input logic [CMD_W-1:0]   bus_wdata_o,
  input logic               bus_ready_i,
  input logic [RESP_W-1:0]  bus_rdata_i,
  input logic               svc_req_o,
  input logic               svc_kind_o,
  input logic               svc_ack_i,
  input logic               done_o,
  input logic               busy_o,
  input logic               err_proto_o,
  input logic               err_timeout_o
);
  p_write_to_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && bus_write_o) |-> (bus_sel_o == 1'b0));

  p_read_from_resp_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && !bus_write_o) |-> (bus_sel_o == 1'b1));

  p_hold_access_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_sel_o) && $stable(bus_write_o) && $stable(bus_wdata_o)));

  p_gap_then_read_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_valid_o) && busy_o && !svc_req_o) |=> bus_valid_o);

  p_svc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (svc_req_o && !svc_ack_i) |=> (svc_req_o && $stable(svc_kind_o)));

  p_svc_no_bus_r5: assert property (@(posedge clk) disable iff (rst)
    svc_req_o |-> !bus_valid_o);

  p_done_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_error_no_done_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_proto_o) || $rose(err_timeout_o)) |-> !done_o);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!bus_valid_o && !svc_req_o));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_proto_o && !busy_o && !start_i) |=> err_proto_o);
endmodule

bind cop_handshake_seq cop_handshake_seq_chk #(
  .CMD_W(CMD_W), .RESP_W(RESP_W), .RETRY_W(RETRY_W)
) u_chk (.*);

// File: tb/cop_handshake_seq_tb.sv
module cop_handshake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_W   = 16;
  localparam int RESP_W  = 8;
  localparam int RETRY_W = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic [CMD_W-1:0]   cmd_word_i = '0;
  logic               trace_pend_i = 1'b0;
  logic [RETRY_W-1:0] retry_limit_i = '0;
  logic               bus_valid_o, bus_write_o, bus_sel_o;
  logic [CMD_W-1:0]   bus_wdata_o;
  logic               bus_ready_i = 1'b0;
  logic [RESP_W-1:0]  bus_rdata_i;
  logic               svc_req_o, svc_kind_o;
  logic               svc_ack_i = 1'b0;
  logic               done_o, busy_o, err_proto_o, err_timeout_o;

  cop_handshake_seq #(.CMD_W(CMD_W), .RESP_W(RESP_W), .RETRY_W(RETRY_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [RESP_W-1:0] script_q [16];
  int stall_n = 0;
  int wait_cnt = 0;
  int cyc = 0, last_rd = 0;
  int wr_cnt, rd_cnt, svc_cnt, done_cnt, done_run, done_run_max, gap_min, gap_max;
  logic [CMD_W-1:0] seen_cmd;
  logic svc_log [4];
  logic overlap, sel_bad;

  assign bus_rdata_i = script_q[(rd_cnt > 15) ? 15 : rd_cnt];

  // Recording at the active edge, on values settled since the previous falling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_valid_o && bus_ready_i) begin
      if (bus_write_o) begin
        wr_cnt   <= wr_cnt + 1;
        seen_cmd <= bus_wdata_o;
        if (bus_sel_o != 1'b0) sel_bad <= 1'b1;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        last_rd <= cyc;
        if (bus_sel_o != 1'b1) sel_bad <= 1'b1;
        if (rd_cnt > 0) begin
          if (cyc - last_rd < gap_min) gap_min <= cyc - last_rd;
          if (cyc - last_rd > gap_max) gap_max <= cyc - last_rd;
        end
      end
    end
    if (svc_req_o && svc_ack_i) begin
      if (svc_cnt < 4) svc_log[svc_cnt] <= svc_kind_o;
      svc_cnt <= svc_cnt + 1;
    end
    if (svc_req_o && bus_valid_o) overlap <= 1'b1;
    if (done_o) begin
      done_cnt <= done_cnt + 1;
      done_run <= done_run + 1;
      if (done_run + 1 > done_run_max) done_run_max <= done_run + 1;
    end else begin
      done_run <= 0;
    end
  end

  // Coprocessor and core models respond on the falling edge
  always @(negedge clk) begin
    svc_ack_i <= svc_req_o;
    if (bus_valid_o) begin
      if (wait_cnt >= stall_n) begin bus_ready_i <= 1'b1; wait_cnt <= 0; end
      else begin bus_ready_i <= 1'b0; wait_cnt <= wait_cnt + 1; end
    end else begin
      bus_ready_i <= 1'b0;
      wait_cnt    <= 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [RESP_W-1:0] a, input logic [RESP_W-1:0] b,
                      input logic [RESP_W-1:0] c, input logic [RESP_W-1:0] d,
                      input logic [RESP_W-1:0] e, input logic [RESP_W-1:0] f);
    for (int i = 0; i < 16; i++) script_q[i] = f;
    script_q[0] = a; script_q[1] = b; script_q[2] = c;
    script_q[3] = d; script_q[4] = e;
  endtask

  task automatic run(input logic [CMD_W-1:0] cmd, input logic trace,
                     input int lim, input int stall, input logic restart);
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; svc_cnt = 0; done_cnt = 0; done_run = 0; done_run_max = 0;
    gap_min = 999; gap_max = 0; overlap = 1'b0; sel_bad = 1'b0; seen_cmd = '0;
    svc_log[0] = 1'b0; svc_log[1] = 1'b0;
    stall_n = stall;
    start_i = 1'b1; cmd_word_i = cmd; trace_pend_i = trace; retry_limit_i = RETRY_W'(lim);
    @(negedge clk);
    start_i = 1'b0;
    check("R10", "busy after start", int'(busy_o), 1);
    if (restart) begin
      @(negedge clk);
      start_i = 1'b1; cmd_word_i = 16'h1111;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 400; i++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10", "reset busy", int'(busy_o), 0);
    check("R3", "reset valid", int'(bus_valid_o), 0);
    check("R10", "reset done", int'(done_o), 0);
    check("R11", "reset errors", int'(err_proto_o) + int'(err_timeout_o), 0);
    check("R5", "reset svc", int'(svc_req_o), 0);
  endtask

  task automatic t_release_full;
    load(8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'hA5C3, 1'b0, 3, 0, 1'b0);
    check("R1", "writes", wr_cnt, 1);
    check("R1", "command word", int'(seen_cmd), 16'hA5C3);
    check("R2", "reads", rd_cnt, 1);
    check("R2", "select use", int'(sel_bad), 0);
    check("R6", "done count", done_cnt, 1);
    check("R10", "done width", done_run_max, 1);
    check("R8", "no error", int'(err_proto_o) + int'(err_timeout_o), 0);
  endtask

  task automatic t_again;
    load(8'h00, 8'h00, 8'h01, 8'h02, 8'h02, 8'h02);
    run(16'h0F0F, 1'b0, 5, 0, 1'b0);
    check("R4", "reads", rd_cnt, 3);
    check("R4", "gap min", gap_min, 2);
    check("R4", "gap max", gap_max, 2);
    check("R6", "part release done", done_cnt, 1);
  endtask

  task automatic t_trace;
    load(8'h01, 8'h01, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h2222, 1'b1, 5, 0, 1'b0);
    check("R7", "reads", rd_cnt, 3);
    check("R7", "done", done_cnt, 1);
    check("R7", "gap", gap_max, 2);
    load(8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
    run(16'h2223, 1'b1, 1, 0, 1'b0);
    check("R7", "limit reads", rd_cnt, 2);
    check("R9", "trace timeout", int'(err_timeout_o), 1);
    check("R7", "no done", done_cnt, 0);
  endtask

  task automatic t_service;
    load(8'h03, 8'h04, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h3333, 1'b0, 5, 0, 1'b0);
    check("R5", "services", svc_cnt, 2);
    check("R5", "first kind", int'(svc_log[0]), 0);
    check("R5", "second kind", int'(svc_log[1]), 1);
    check("R5", "bus quiet", int'(overlap), 0);
    check("R5", "reads", rd_cnt, 3);
    check("R5", "done", done_cnt, 1);
  endtask

  task automatic t_proto;
    load(8'h05, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h4444, 1'b0, 5, 0, 1'b0);
    check("R8", "code 101 error", int'(err_proto_o), 1);
    check("R8", "no done", done_cnt, 0);
    check("R8", "reads", rd_cnt, 1);
    @(negedge clk);
    check("R11", "error held", int'(err_proto_o), 1);
    load(8'h12, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h4445, 1'b0, 5, 0, 1'b0);
    check("R8", "upper bits error", int'(err_proto_o), 1);
    check("R8", "upper bits no done", done_cnt, 0);
    load(8'h07, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h4446, 1'b0, 5, 0, 1'b0);
    check("R8", "code 111 error", int'(err_proto_o), 1);
    load(8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h4447, 1'b0, 5, 0, 1'b0);
    check("R11", "error cleared", int'(err_proto_o), 0);
    check("R11", "done after clear", done_cnt, 1);
  endtask

  task automatic t_timeout;
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run(16'h5555, 1'b0, 2, 0, 1'b0);
    check("R9", "reads limit 2", rd_cnt, 3);
    check("R9", "timeout flag", int'(err_timeout_o), 1);
    check("R9", "no done", done_cnt, 0);
    run(16'h5556, 1'b0, 0, 0, 1'b0);
    check("R9", "reads limit 0", rd_cnt, 1);
    check("R9", "timeout limit 0", int'(err_timeout_o), 1);
    load(8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h02);
    run(16'h5557, 1'b0, 2, 0, 1'b0);
    check("R9", "service restarts count", int'(err_timeout_o), 0);
    check("R9", "done after restart", done_cnt, 1);
    check("R9", "reads", rd_cnt, 6);
    check("R11", "timeout cleared", int'(err_timeout_o), 0);
  endtask

  task automatic t_stall;
    load(8'h00, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02);
    run(16'h6666, 1'b0, 3, 2, 1'b0);
    check("R3", "writes", wr_cnt, 1);
    check("R3", "reads", rd_cnt, 2);
    check("R3", "done", done_cnt, 1);
    check("R3", "select use", int'(sel_bad), 0);
    stall_n = 0;
  endtask

  task automatic t_restart;
    load(8'h00, 8'h00, 8'h00, 8'h02, 8'h02, 8'h02);
    run(16'h7777, 1'b0, 5, 0, 1'b1);
    check("R10", "one write", wr_cnt, 1);
    check("R10", "first word kept", int'(seen_cmd), 16'h7777);
    check("R10", "one done", done_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) script_q[i] = 8'h02;
    wr_cnt = 0; rd_cnt = 0; svc_cnt = 0; done_cnt = 0; done_run = 0; done_run_max = 0;
    gap_min = 999; gap_max = 0; overlap = 1'b0; sel_bad = 1'b0; seen_cmd = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_release_full();
    t_again();
    t_trace();
    t_service();
    t_proto();
    t_timeout();
    t_stall();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule